// File: doc/BRIEF.md
# LCD Controller Register File

This block is the software-visible configuration and status store of a simple LCD controller. A 32-bit read/write port with a byte address reaches six word registers inside a 256-byte window: control, three timing words, status and sub-panel. The block turns the stored words into decoded fields for the display pipeline: the master enable, palette loading mode, active-matrix and monochrome selects, panel width and height (both held as count minus one) and two interrupt enables.

The frame fetch logic reports events through three one-cycle set inputs: frame done, palette loaded and synchronisation error. Each event sets a sticky status flag. Software clears a flag by writing a 1 to its bit. The flags and the enables drive a single level interrupt. Some reads return fixed reserved-bit patterns ORed into the stored fields.

A two-state enable machine (states `EN_OFF` and `EN_ON`) holds the master enable. A control write with bit 0 set moves `EN_OFF` to `EN_ON`. A control write with bit 0 clear moves `EN_ON` to `EN_OFF`. Each of these transitions raises `en_pulse` for one cycle toward the frame fetch sequencer. A control write that leaves bit 0 unchanged stays in the current state and raises no pulse.

Top module: `lcdc_regs`

## Requirements
- R1: After reset all stored fields are zero, `lcd_enable`, `en_pulse` and `irq` are low. Reads return 0xfe000c34 from offset 0x00, 0x0000000f from 0x04, 0xfc000000 from 0x0c and 0 from 0x08, 0x10 and 0x14.
- R2: Control (offset 0x00) holds palette mode at bits 21:20, active-matrix at bit 7, interrupt enables at bits 4:3, mono at bit 1 and enable at bit 0, plus other write bits under mask 0x01cff300. A read returns those fields ORed with 0xfe000c34, with the active-matrix bit also shown at bit 23. The decoded fields appear on the outputs after the write edge.
- R3: Timing word 0 (offset 0x04) takes width minus one from bits 9:0, shown on `panel_w_m1`, and keeps bits 31:10. A read returns the stored word ORed with 0xf.
- R4: Timing word 1 (offset 0x08) takes height minus one from bits 9:0, shown on `panel_h_m1`, keeps bits 31:10, and reads back unchanged.
- R5: Timing word 2 (offset 0x0c) stores the whole word. A read returns it ORed with 0xfc000000.
- R6: A sub-panel write (offset 0x14) stores the data ANDed with 0xa1ffffff, and a read returns the stored value.
- R7: A high set input makes its status flag 1 from the next edge until it is cleared: palette loaded at bit 6, sync error at bit 2, frame done at bit 0 of offset 0x10. A set wins over a clear in the same cycle.
- R8: Writing 1 to a status bit (0, 2 or 6) clears that flag. Writing 0 leaves it unchanged.
- R9: `irq` is high exactly when frame done is set with enable bit 3, or palette loaded is set with enable bit 4, or sync error is set. It changes only after a set input or a bus write.
- R10: `en_pulse` is high for exactly the cycle after a control write that changes bit 0, and `lcd_enable` follows bit 0 from that same edge.
- R11: An offset that is not a multiple of four, or is above 0x14, is undefined. Writes to it change nothing, and reads of it return 0.
- R12: `bus_rdata` is loaded on the edge where `bus_rd` is high and holds its value while `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (8) | Byte address within the window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| set_frame_done | input | 1 | Frame fetch: frame finished |
| set_pal_loaded | input | 1 | Frame fetch: palette loaded |
| set_sync_err | input | 1 | Frame fetch: synchronisation error |
| lcd_enable | output | 1 | Master enable |
| en_pulse | output | 1 | One-cycle pulse on an enable change |
| pal_mode | output | 2 | Palette loading mode |
| tft_mode | output | 1 | Active-matrix panel select |
| mono_mode | output | 1 | Monochrome select |
| irq_en | output | 2 | Interrupt enables (0: frame, 1: palette) |
| panel_w_m1 | output | DIM_W (10) | Pixels per line minus one |
| panel_h_m1 | output | DIM_W (10) | Lines per panel minus one |
| irq | output | 1 | Level interrupt |

## Verification
The write-then-read table uses all-ones, all-zeros and mixed patterns on every defined offset. All-ones shows where stored fields and fixed read patterns overlap. All-zeros isolates the fixed patterns and the sub-panel mask. Mixed words show that each field sits at its own bit position. The directed part sets each flag with its enable off and then on, so the enable gating on `irq` is separated from the unconditional sync error path. It also tries a set and a clear in the same cycle, enable writes that do and do not change bit 0, and misaligned or out-of-range offsets.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;
    localparam int DATA_W = 32;

    typedef enum logic [2:0] {
        REG_CTRL = 3'd0,
        REG_TIM0 = 3'd1,
        REG_TIM1 = 3'd2,
        REG_TIM2 = 3'd3,
        REG_STAT = 3'd4,
        REG_SUBP = 3'd5
    } lcdc_reg_e;

    localparam int NUM_REGS = 6;

    typedef enum logic {
        EN_OFF = 1'b0,
        EN_ON  = 1'b1
    } en_state_e;

    // fixed read patterns and write masks
    localparam logic [DATA_W-1:0] CTRL_RD_FIXED = 32'hfe00_0c34;
    localparam logic [DATA_W-1:0] CTRL_MISC_MSK = 32'h01cf_f300;
    localparam logic [DATA_W-1:0] TIM0_RD_FIXED = 32'h0000_000f;
    localparam logic [DATA_W-1:0] TIM2_RD_FIXED = 32'hfc00_0000;
    localparam logic [DATA_W-1:0] SUBP_WR_MSK   = 32'ha1ff_ffff;

    // bit positions inside control and status
    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_MONO_BIT = 1;
    localparam int CTRL_IE_LSB   = 3;
    localparam int CTRL_TFT_BIT  = 7;
    localparam int CTRL_TFT_HI   = 23;
    localparam int CTRL_PLM_LSB  = 20;
    localparam int STAT_FRM_BIT  = 0;
    localparam int STAT_SYN_BIT  = 2;
    localparam int STAT_PAL_BIT  = 6;
endpackage

// File: rtl/lcdc_addr_dec.sv
module lcdc_addr_dec
    import lcdc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_REGS-1:0] sel,
    output logic                hit,
    output lcdc_reg_e           idx
);
    localparam int IDX_W = ADDR_W - 2;

    logic aligned;
    assign aligned = (addr[1:0] == 2'b00);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
        assign sel[g] = aligned && (addr[ADDR_W-1:2] == IDX_W'(g));
    end

    assign hit = |sel;
    assign idx = lcdc_reg_e'(addr[4:2]);
endmodule

// File: rtl/lcdc_status.sv
module lcdc_status
    import lcdc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_wr,
    input  logic [DATA_W-1:0] clr_data,
    input  logic              set_frame,
    input  logic              set_pal,
    input  logic              set_sync,
    input  logic [1:0]        ie,
    output logic              flg_frame,
    output logic              flg_pal,
    output logic              flg_sync,
    output logic              irq
);
    logic clr_frame, clr_pal, clr_sync;

    assign clr_frame = clr_wr && clr_data[STAT_FRM_BIT];
    assign clr_pal   = clr_wr && clr_data[STAT_PAL_BIT];
    assign clr_sync  = clr_wr && clr_data[STAT_SYN_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flg_frame <= 1'b0;
            flg_pal   <= 1'b0;
            flg_sync  <= 1'b0;
        end else begin
            flg_frame <= set_frame || (flg_frame && !clr_frame);
            flg_pal   <= set_pal   || (flg_pal   && !clr_pal);
            flg_sync  <= set_sync  || (flg_sync  && !clr_sync);
        end
    end

    assign irq = (flg_frame && ie[0]) || (flg_pal && ie[1]) || flg_sync;
endmodule

// File: rtl/lcdc_en_fsm.sv
module lcdc_en_fsm
    import lcdc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic want_en,
    output logic lcd_enable,
    output logic en_pulse
);
    en_state_e state, state_nx;
    logic      pulse_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= EN_OFF;
            en_pulse <= 1'b0;
        end else begin
            state    <= state_nx;
            en_pulse <= pulse_nx;
        end
    end

    always_comb begin
        state_nx = state;
        pulse_nx = 1'b0;
        unique case (state)
            EN_OFF: if (ctrl_wr && want_en) begin
                state_nx = EN_ON;
                pulse_nx = 1'b1;
            end
            EN_ON: if (ctrl_wr && !want_en) begin
                state_nx = EN_OFF;
                pulse_nx = 1'b1;
            end
        endcase
    end

    assign lcd_enable = (state == EN_ON);
endmodule

// File: rtl/lcdc_regs.sv
module lcdc_regs
    import lcdc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DIM_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              set_frame_done,
    input  logic              set_pal_loaded,
    input  logic              set_sync_err,
    output logic              lcd_enable,
    output logic              en_pulse,
    output logic [1:0]        pal_mode,
    output logic              tft_mode,
    output logic              mono_mode,
    output logic [1:0]        irq_en,
    output logic [DIM_W-1:0]  panel_w_m1,
    output logic [DIM_W-1:0]  panel_h_m1,
    output logic              irq
);
    localparam int HI_W = DATA_W - DIM_W;

    logic [NUM_REGS-1:0] sel;
    logic                hit;
    lcdc_reg_e           idx;

    lcdc_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel),
        .hit  (hit),
        .idx  (idx)
    );

    logic wr_ctrl, wr_tim0, wr_tim1, wr_tim2, wr_stat, wr_subp;
    assign wr_ctrl = bus_wr && sel[REG_CTRL];
    assign wr_tim0 = bus_wr && sel[REG_TIM0];
    assign wr_tim1 = bus_wr && sel[REG_TIM1];
    assign wr_tim2 = bus_wr && sel[REG_TIM2];
    assign wr_stat = bus_wr && sel[REG_STAT];
    assign wr_subp = bus_wr && sel[REG_SUBP];

    logic [DATA_W-1:0] ctrl_misc, tim2_q, subp_q;
    logic [HI_W-1:0]   tim0_hi, tim1_hi;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_misc  <= '0;
            pal_mode   <= '0;
            tft_mode   <= 1'b0;
            irq_en     <= '0;
            mono_mode  <= 1'b0;
            tim0_hi    <= '0;
            panel_w_m1 <= '0;
            tim1_hi    <= '0;
            panel_h_m1 <= '0;
            tim2_q     <= '0;
            subp_q     <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_misc <= bus_wdata & CTRL_MISC_MSK;
                pal_mode  <= bus_wdata[CTRL_PLM_LSB +: 2];
                tft_mode  <= bus_wdata[CTRL_TFT_BIT];
                irq_en    <= bus_wdata[CTRL_IE_LSB +: 2];
                mono_mode <= bus_wdata[CTRL_MONO_BIT];
            end
            if (wr_tim0) begin
                tim0_hi    <= bus_wdata[DATA_W-1:DIM_W];
                panel_w_m1 <= bus_wdata[DIM_W-1:0];
            end
            if (wr_tim1) begin
                tim1_hi    <= bus_wdata[DATA_W-1:DIM_W];
                panel_h_m1 <= bus_wdata[DIM_W-1:0];
            end
            if (wr_tim2) tim2_q <= bus_wdata;
            if (wr_subp) subp_q <= bus_wdata & SUBP_WR_MSK;
        end
    end

    logic flg_frame, flg_pal, flg_sync;

    lcdc_status u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_wr    (wr_stat),
        .clr_data  (bus_wdata),
        .set_frame (set_frame_done),
        .set_pal   (set_pal_loaded),
        .set_sync  (set_sync_err),
        .ie        (irq_en),
        .flg_frame (flg_frame),
        .flg_pal   (flg_pal),
        .flg_sync  (flg_sync),
        .irq       (irq)
    );

    lcdc_en_fsm u_en (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (wr_ctrl),
        .want_en    (bus_wdata[CTRL_EN_BIT]),
        .lcd_enable (lcd_enable),
        .en_pulse   (en_pulse)
    );

    logic [DATA_W-1:0] ctrl_rd, stat_rd, rd_word;

    always_comb begin
        ctrl_rd = CTRL_RD_FIXED | ctrl_misc;
        ctrl_rd[CTRL_PLM_LSB +: 2] = ctrl_rd[CTRL_PLM_LSB +: 2] | pal_mode;
        ctrl_rd[CTRL_TFT_HI]       = ctrl_rd[CTRL_TFT_HI] | tft_mode;
        ctrl_rd[CTRL_TFT_BIT]      = ctrl_rd[CTRL_TFT_BIT] | tft_mode;
        ctrl_rd[CTRL_IE_LSB +: 2]  = ctrl_rd[CTRL_IE_LSB +: 2] | irq_en;
        ctrl_rd[CTRL_MONO_BIT]     = ctrl_rd[CTRL_MONO_BIT] | mono_mode;
        ctrl_rd[CTRL_EN_BIT]       = ctrl_rd[CTRL_EN_BIT] | lcd_enable;
    end

    always_comb begin
        stat_rd = '0;
        stat_rd[STAT_FRM_BIT] = flg_frame;
        stat_rd[STAT_SYN_BIT] = flg_sync;
        stat_rd[STAT_PAL_BIT] = flg_pal;
    end

    always_comb begin
        rd_word = '0;
        if (hit) begin
            unique case (idx)
                REG_CTRL: rd_word = ctrl_rd;
                REG_TIM0: rd_word = {tim0_hi, panel_w_m1} | TIM0_RD_FIXED;
                REG_TIM1: rd_word = {tim1_hi, panel_h_m1};
                REG_TIM2: rd_word = tim2_q | TIM2_RD_FIXED;
                REG_STAT: rd_word = stat_rd;
                REG_SUBP: rd_word = subp_q;
                default:  rd_word = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_word;
    end
endmodule

// File: rtl/lcdc_regs_chk.sv
module lcdc_regs_chk #(
    parameter int ADDR_W = 8,
    parameter int DIM_W  = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              set_frame_done,
    input logic              set_pal_loaded,
    input logic              set_sync_err,
    input logic              lcd_enable,
    input logic              en_pulse,
    input logic [DIM_W-1:0]  panel_w_m1,
    input logic              irq
);
    logic undef_addr;
    assign undef_addr = (bus_addr[1:0] != 2'b00) || (bus_addr > ADDR_W'(8'h14));

    AST_SYNC_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        set_sync_err |=> irq);  // R9

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(bus_wr) && !$past(set_frame_done) && !$past(set_pal_loaded)
         && !$past(set_sync_err)) |-> $stable(irq));  // R9

    AST_PULSE_ON_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        en_pulse == (lcd_enable != $past(lcd_enable)));  // R10

    AST_UNDEF_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && undef_addr) |=> (bus_rdata == 32'h0));  // R11

    AST_CTRL_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(0)) |=>
        ((bus_rdata & 32'hfe000c34) == 32'hfe000c34));  // R2

    AST_TFT_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(0)) |=> (!bus_rdata[7] || bus_rdata[23]));  // R2

    AST_WIDTH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(4)) |=> (panel_w_m1 == $past(bus_wdata[DIM_W-1:0])));  // R3

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));  // R12
endmodule

bind lcdc_regs lcdc_regs_chk #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_addr       (bus_addr),
    .bus_wr         (bus_wr),
    .bus_rd         (bus_rd),
    .bus_wdata      (bus_wdata),
    .bus_rdata      (bus_rdata),
    .set_frame_done (set_frame_done),
    .set_pal_loaded (set_pal_loaded),
    .set_sync_err   (set_sync_err),
    .lcd_enable     (lcd_enable),
    .en_pulse       (en_pulse),
    .panel_w_m1     (panel_w_m1),
    .irq            (irq)
);

// File: tb/test_lcdc_regs.sv
`timescale 1ns/1ps
module test_lcdc_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        set_frame_done = 1'b0;
    logic        set_pal_loaded = 1'b0;
    logic        set_sync_err = 1'b0;
    logic        lcd_enable, en_pulse, tft_mode, mono_mode, irq;
    logic [1:0]  pal_mode, irq_en;
    logic [9:0]  panel_w_m1, panel_h_m1;

    int checks = 0;
    int errors = 0;
    logic pulse_seen;
    logic [31:0] rd_val;

    always #2 clk = ~clk;

    lcdc_regs i_lcdc_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .bus_addr       (bus_addr),
        .bus_wr         (bus_wr),
        .bus_rd         (bus_rd),
        .bus_wdata      (bus_wdata),
        .bus_rdata      (bus_rdata),
        .set_frame_done (set_frame_done),
        .set_pal_loaded (set_pal_loaded),
        .set_sync_err   (set_sync_err),
        .lcd_enable     (lcd_enable),
        .en_pulse       (en_pulse),
        .pal_mode       (pal_mode),
        .tft_mode       (tft_mode),
        .mono_mode      (mono_mode),
        .irq_en         (irq_en),
        .panel_w_m1     (panel_w_m1),
        .panel_h_m1     (panel_h_m1),
        .irq            (irq)
    );

    // {addr, write data, expected read}
    localparam logic [71:0] VEC [12] = '{
        {8'h00, 32'hffffffff, 32'hffffffbf},
        {8'h00, 32'h00000000, 32'hfe000c34},
        {8'h00, 32'h00100082, 32'hfe900cb6},
        {8'h04, 32'h12345678, 32'h1234567f},
        {8'h04, 32'h00000000, 32'h0000000f},
        {8'h08, 32'habcdef01, 32'habcdef01},
        {8'h0c, 32'h00000123, 32'hfc000123},
        {8'h0c, 32'hffffffff, 32'hffffffff},
        {8'h14, 32'hffffffff, 32'ha1ffffff},
        {8'h14, 32'h5e000000, 32'h00000000},
        {8'h18, 32'hffffffff, 32'h00000000},
        {8'hfc, 32'h12345678, 32'h00000000}
    };

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        pulse_seen = en_pulse;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        rd_val = bus_rdata;
        bus_rd = 1'b0;
    endtask

    function automatic string tag_of(input logic [7:0] a);
        case (a)
            8'h00:   return "R2 control";
            8'h04:   return "R3 timing0";
            8'h08:   return "R4 timing1";
            8'h0c:   return "R5 timing2";
            8'h14:   return "R6 subpanel";
            default: return "R11 undefined";
        endcase
    endfunction

    initial begin
        #(4 * 100000);
        errors++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk({29'b0, lcd_enable, en_pulse, irq}, 32'h0, "R1 outputs");
        rd(8'h00); chk(rd_val, 32'hfe000c34, "R1 control");
        rd(8'h04); chk(rd_val, 32'h0000000f, "R1 timing0");
        rd(8'h08); chk(rd_val, 32'h0, "R1 timing1");
        rd(8'h0c); chk(rd_val, 32'hfc000000, "R1 timing2");
        rd(8'h10); chk(rd_val, 32'h0, "R1 status");
        rd(8'h14); chk(rd_val, 32'h0, "R1 subpanel");

        foreach (VEC[i]) begin
            wr(VEC[i][71:64], VEC[i][63:32]);
            if (VEC[i][71:64] == 8'h04)
                chk(32'(panel_w_m1), 32'(VEC[i][41:32]), "R3 width out");
            if (VEC[i][71:64] == 8'h08)
                chk(32'(panel_h_m1), 32'(VEC[i][41:32]), "R4 height out");
            rd(VEC[i][71:64]);
            chk(rd_val, VEC[i][31:0], tag_of(VEC[i][71:64]));
        end

        // R2 decoded control fields from 0x00100082
        chk({26'b0, pal_mode, tft_mode, mono_mode, irq_en}, {26'b0, 2'd1, 1'b1, 1'b1, 2'd0}, "R2 fields");

        // R11 misaligned write leaves sub-panel and control alone
        wr(8'h15, 32'hffffffff);
        rd(8'h14); chk(rd_val, 32'h0, "R11 subpanel kept");
        rd(8'h15); chk(rd_val, 32'h0, "R11 misaligned read");
        rd(8'h00); chk(rd_val, 32'hfe900cb6, "R11 control kept");

        // R12 hold while bus_rd low
        @(negedge clk); bus_addr = 8'h04;
        @(negedge clk); chk(bus_rdata, 32'hfe900cb6, "R12 hold");

        // R7 R9 frame flag, gated by enable bit 3
        wr(8'h00, 32'h0);
        @(negedge clk); set_frame_done = 1'b1;
        @(negedge clk); set_frame_done = 1'b0;
        rd(8'h10); chk(rd_val, 32'h1, "R7 frame flag");
        chk(32'(irq), 32'h0, "R9 frame masked");
        wr(8'h00, 32'h08);
        chk(32'(irq), 32'h1, "R9 frame enabled");
        wr(8'h10, 32'h0);
        rd(8'h10); chk(rd_val, 32'h1, "R8 zero write");
        wr(8'h10, 32'h1);
        rd(8'h10); chk(rd_val, 32'h0, "R8 clear frame");
        chk(32'(irq), 32'h0, "R9 after clear");

        // palette flag, gated by enable bit 4
        @(negedge clk); set_pal_loaded = 1'b1;
        @(negedge clk); set_pal_loaded = 1'b0;
        rd(8'h10); chk(rd_val, 32'h40, "R7 palette flag");
        chk(32'(irq), 32'h0, "R9 palette masked");
        wr(8'h00, 32'h10);
        chk(32'(irq), 32'h1, "R9 palette enabled");
        wr(8'h10, 32'h40);
        chk(32'(irq), 32'h0, "R8 clear palette");

        // sync error ungated
        wr(8'h00, 32'h0);
        @(negedge clk); set_sync_err = 1'b1;
        @(negedge clk); set_sync_err = 1'b0;
        chk(32'(irq), 32'h1, "R9 sync error");
        rd(8'h10); chk(rd_val, 32'h4, "R7 sync flag");
        wr(8'h10, 32'h4);
        chk(32'(irq), 32'h0, "R8 clear sync");

        // R7 set wins over clear
        @(negedge clk);
        set_frame_done = 1'b1; bus_addr = 8'h10; bus_wdata = 32'h1; bus_wr = 1'b1;
        @(negedge clk);
        set_frame_done = 1'b0; bus_wr = 1'b0;
        rd(8'h10); chk(rd_val, 32'h1, "R7 set beats clear");
        wr(8'h10, 32'h1);

        // R10 enable pulses
        wr(8'h00, 32'h1);
        chk({30'b0, pulse_seen, lcd_enable}, 32'h3, "R10 rise");
        @(negedge clk); chk(32'(en_pulse), 32'h0, "R10 one cycle");
        wr(8'h00, 32'h1);
        chk({30'b0, pulse_seen, lcd_enable}, 32'h1, "R10 no change");
        wr(8'h00, 32'h0);
        chk({30'b0, pulse_seen, lcd_enable}, 32'h2, "R10 fall");

        repeat (2) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule